// File: doc/BRIEF.md
# Auto-Incrementing Status Readout Window

This block lets a host read a whole bank of 8-bit status and counter words through one register address. A hidden read pointer selects the word returned by each read. The pointer goes back to word zero whenever chip select is high. While chip select stays low, every read of the window address returns the word under the pointer and then moves the pointer on by one. A full pass over the bank therefore takes one access made of back-to-back reads.

The host side is a plain register bus with chip select, read strobe, write strobe and address. It has no back-pressure. Each read is taken in the cycle its strobe is sampled, and the data shows up on the read bus in the following cycle. There is no valid/ready pairing at either edge, because the host sets the pace and the block never stalls. The status words come in as one flat bus and are sampled at the moment of the read.

Top module: `status_window`

## Requirements
- R1: When reset is released, the read data bus is zero and the read pointer is at word 0.
- R2: In a new access (chip select low after being high or after reset), the first read of the window address (15) returns word 0.
- R3: Each window read in the same access moves the pointer up by one, so successive reads return words 1, 2, … 52 in ascending order. Word k sits at bits [8k+7:8k] of the status bus.
- R4: Any cycle with chip select high puts the pointer back to word 0. The next access then starts again at word 0.
- R5: After word 52 has been read, further window reads in the same access return zero, and the pointer stays at its end value.
- R6: A cycle with the write strobe high is not a read, even if the read strobe is also high. Such a cycle returns zero and leaves the pointer where it was.
- R7: A read of any address other than 15 returns zero and does not move the pointer.
- R8: The read data bus changes one cycle after the sampling edge of a read. It is zero after every cycle that is not a window read.
- R9: Idle cycles with chip select low do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; high restarts the walk |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (writes are ignored) |
| addr | input | 4 | Host register address |
| status | input | 424 | 53 status words, word k at bits [8k+7:8k] |
| rd_data | output | 8 | Registered read data |

## Verification
A pointer that is off by one, or that fails to restart, shows up on the very next window read, because the bus then returns a neighbouring word, and the bench fills every word with a distinct nonzero value. A pointer that moves on writes, on idle cycles or on reads of other addresses shifts every later word in the same access. The bench exposes this by making one window read straight after each such cycle. Wrong end-of-bank handling shows up within one cycle of reading past word 52, as a nonzero value or as a wrap back to a low word.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int DEF_ENTRIES  = 53;
  localparam int DEF_DATA_W   = 8;
  localparam int DEF_ADDR_W   = 4;
  localparam int DEF_WIN_ADDR = 15;
endpackage

// File: rtl/srw_decode.sv
module srw_decode #(
  parameter int ADDR_W   = srw_pkg::DEF_ADDR_W,
  parameter int WIN_ADDR = srw_pkg::DEF_WIN_ADDR
) (
  input  logic              cs_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              restart
);
  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_ADDR);

  // a write strobe turns the cycle into an ignored write
  assign hit     = !cs_n && rd_en && !wr_en && (addr == WIN);
  assign restart = cs_n;
endmodule

// File: rtl/srw_pointer.sv
module srw_pointer #(
  parameter int ENTRIES = srw_pkg::DEF_ENTRIES,
  parameter int PTR_W   = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  // value ENTRIES marks "bank exhausted"
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(ENTRIES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (restart)
      ptr <= '0;
    else if (step && ptr != LIMIT)
      ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/srw_select.sv
module srw_select #(
  parameter int ENTRIES = srw_pkg::DEF_ENTRIES,
  parameter int DATA_W  = srw_pkg::DEF_DATA_W,
  parameter int PTR_W   = $clog2(ENTRIES + 1)
) (
  input  logic [ENTRIES*DATA_W-1:0] status,
  input  logic [PTR_W-1:0]          idx,
  output logic [DATA_W-1:0]         word
);
  logic [DATA_W-1:0] words [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_unpack
    assign words[g] = status[g*DATA_W +: DATA_W];
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (idx == PTR_W'(i)) word = words[i];
  end
endmodule

// File: rtl/status_window.sv
module status_window #(
  parameter int ENTRIES  = srw_pkg::DEF_ENTRIES,
  parameter int DATA_W   = srw_pkg::DEF_DATA_W,
  parameter int ADDR_W   = srw_pkg::DEF_ADDR_W,
  parameter int WIN_ADDR = srw_pkg::DEF_WIN_ADDR
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      rd_en,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [ENTRIES*DATA_W-1:0] status,
  output logic [DATA_W-1:0]         rd_data
);
  localparam int PTR_W = $clog2(ENTRIES + 1);

  logic              hit;
  logic              restart;
  logic [PTR_W-1:0]  cur_ptr;
  logic [DATA_W-1:0] sel_word;

  srw_decode #(.ADDR_W(ADDR_W), .WIN_ADDR(WIN_ADDR)) u_decode (
    .cs_n(cs_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .hit(hit), .restart(restart)
  );

  srw_pointer #(.ENTRIES(ENTRIES), .PTR_W(PTR_W)) u_pointer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .step(hit), .ptr(cur_ptr)
  );

  srw_select #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_select (
    .status(status), .idx(cur_ptr), .word(sel_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else
      rd_data <= hit ? sel_word : '0;
  end
endmodule

// File: rtl/status_window_chk.sv
module status_window_chk #(
  parameter int ENTRIES  = srw_pkg::DEF_ENTRIES,
  parameter int DATA_W   = srw_pkg::DEF_DATA_W,
  parameter int ADDR_W   = srw_pkg::DEF_ADDR_W,
  parameter int WIN_ADDR = srw_pkg::DEF_WIN_ADDR,
  parameter int PTR_W    = $clog2(ENTRIES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] entry0,
  input logic [DATA_W-1:0] rd_data,
  input logic [PTR_W-1:0]  ptr
);
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(ENTRIES);
  logic win_rd;
  assign win_rd = !cs_n && rd_en && !wr_en && (addr == ADDR_W'(WIN_ADDR));

  // R2
  first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd && ptr == '0 |=> rd_data == $past(entry0));
  // R3
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd && ptr < LIMIT |=> ptr == $past(ptr) + 1'b1);
  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ptr == '0);
  // R5
  past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd && ptr == LIMIT |=> rd_data == '0 && ptr == LIMIT);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n && !win_rd |=> $stable(ptr));
  // R8
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_rd |=> rd_data == '0);
endmodule

bind status_window status_window_chk #(
  .ENTRIES(ENTRIES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_ADDR(WIN_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .entry0(status[DATA_W-1:0]), .rd_data(rd_data), .ptr(cur_ptr)
);

// File: tb/status_window_test.sv
module status_window_test;
  localparam int N = 53;
  localparam int W = 8;
  localparam logic [7:0] ZERO = 8'hFF; // expected-index code meaning "zero"

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [N*W-1:0] status;
  logic [W-1:0] rd_data;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  status_window uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_en(rd_en),
    .wr_en(wr_en), .addr(addr), .status(status), .rd_data(rd_data));

  function automatic logic [7:0] word_of(input int k);
    return 8'(k * 7 + 3);
  endfunction

  function automatic logic [7:0] exp_of(input logic [7:0] code);
    return (code == ZERO) ? 8'h00 : word_of(int'(code));
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  // drive at a falling edge; result is visible at the next falling edge
  task automatic cyc(input logic c, input logic r, input logic w, input logic [3:0] a);
    cs_n = c; rd_en = r; wr_en = w; addr = a;
    @(negedge clk);
  endtask

  // {cs_n, rd_en, wr_en, addr[3:0], expected index code[7:0]}
  localparam int NV = 12;
  localparam logic [14:0] VEC [NV] = '{
    {3'b100, 4'd0,  ZERO},   // R4 idle with chip select high
    {3'b010, 4'd15, 8'd0},   // R2 first read
    {3'b010, 4'd15, 8'd1},   // R3
    {3'b000, 4'd15, ZERO},   // R9 idle, R8 quiet bus
    {3'b010, 4'd15, 8'd2},   // R9 pointer held
    {3'b010, 4'd3,  ZERO},   // R7 other address
    {3'b010, 4'd15, 8'd3},   // R7 pointer not moved
    {3'b001, 4'd15, ZERO},   // R6 write
    {3'b011, 4'd15, ZERO},   // R6 read plus write
    {3'b010, 4'd15, 8'd4},   // R6 pointer not moved
    {3'b110, 4'd15, ZERO},   // R4 chip select high
    {3'b010, 4'd15, 8'd0}    // R4 restart at word 0
  };

  initial begin
    for (int k = 0; k < N; k++) status[k*W +: W] = word_of(k);
    repeat (2) @(negedge clk);
    check("R1 during reset", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 8'h00);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:8]);
      check($sformatf("R2/R3/R4/R6/R7/R8/R9 vector %0d", i), exp_of(VEC[i][7:0]));
    end

    // full walk of the bank
    cyc(1'b1, 1'b0, 1'b0, 4'd0);
    for (int k = 0; k < N; k++) begin
      cyc(1'b0, 1'b1, 1'b0, 4'd15);
      check($sformatf("R3 word %0d", k), word_of(k));
    end
    for (int j = 0; j < 3; j++) begin
      cyc(1'b0, 1'b1, 1'b0, 4'd15);
      check("R5 past end", 8'h00);
    end
    cyc(1'b0, 1'b0, 1'b0, 4'd15);
    check("R8 idle after end", 8'h00);
    cyc(1'b1, 1'b0, 1'b0, 4'd0);
    cyc(1'b0, 1'b1, 1'b0, 4'd15);
    check("R4 restart after end", word_of(0));

    // reset in the middle of an access
    cyc(1'b0, 1'b1, 1'b0, 4'd15);
    check("R3 word 1 before reset", word_of(1));
    cs_n = 1'b0; rd_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears bus", 8'h00);
    rst_n = 1'b1;
    cyc(1'b0, 1'b1, 1'b0, 4'd15);
    check("R1 pointer at word 0 after reset", word_of(0));

    // the read samples the status bus at the read edge
    status[W +: W] = 8'hA5;
    cyc(1'b0, 1'b1, 1'b0, 4'd15);
    check("R3 live word 1", 8'hA5);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule